// File: doc/BRIEF.md
# Switch-Gated Compare-Swap Pulse-Width Modulator

This block is a left-aligned pulse-width modulator. It runs on a fast system clock. Its counter advances only on a count-enable strobe, which stands in for a slower counter clock. Software programs three values: a period, an active compare value and a buffered compare value. The counter runs from zero up to the period value. The line output stays high while the count is below the active compare value.

When swapping is enabled, the active and buffered compare values exchange at terminal count. This happens only if a switch event was seen during the period that is ending. Software can therefore refill the buffered value each period, prompted by a terminal-count flag, and get glitch-free duty changes. A two-fast-cycle overflow pulse marks each terminal count.

The switch input first passes through a synchronizer on the fast clock. It is then sampled only on count strobes, and the sampled value is edge-detected with a selectable polarity. A useful hookup loops the complemented line output back to the switch input with falling-edge detection. This raises one switch event every period.

Top module: `swap_pwm`

## Requirements
- R1: The period value P (reset value 9) gives P+1 strobes per period. On each strobe the counter steps up by one, and on the strobe that finds it at or above P it wraps to 0. That strobe is the terminal count (tc).
- R2: `line` is high exactly while the counter is below the active compare value, and `line_n` is always its complement. With P=9 and compare 2, each period gives 2 strobes high and 8 low.
- R3: With swapping enabled (control bit 0 = 1), the active and buffered compare values exchange at a tc if a switch event occurred on any strobe of the ending period, including the tc strobe itself. With P=9, compare 2 and buffer 6, the line shows high 2, low 8, high 6, low 4, and then repeats.
- R4: With swapping enabled, a tc in a period that had no switch event leaves the active compare value unchanged.
- R5: With control bit 0 = 0, no exchange ever happens, whatever happens on the switch input.
- R6: Control bit 1 selects the switch edge: 0 = a low-to-high change between consecutive strobe samples, 1 = a high-to-low change.
- R7: The switch input passes through a two-flop synchronizer and is sampled only on strobes. A pulse that starts and ends between two strobes raises no event.
- R8: `ov` goes high on the fast-clock cycle after each tc strobe and stays high for exactly two fast-clock cycles.
- R9: `tc_flag` is set by each tc. A control write with bit 2 = 1 clears it, but a tc in the same cycle wins. Register write selects are: 0 = period, 1 = active compare, 2 = buffered compare, 3 = control.
- R10: The recorded switch event is cleared at every tc, whether or not a swap took place.
- R11: After reset the counter is 0 and both compare values and the control bits are 0, so `line`=0, `line_n`=1, `ov`=0 and `tc_flag`=0.
- R12: Looping `line_n` back to the switch input with falling-edge detection swaps at every tc, both for compare 1 and for compare equal to P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-enable strobe, one fast cycle wide |
| sw_in | input | 1 | Asynchronous switch input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 compare, 2 buffer, 3 control |
| wr_data | input | CNT_W | Write data; control bits: 0 swap enable, 1 falling edge, 2 clear flag |
| line | output | 1 | PWM line output |
| line_n | output | 1 | Complement of line |
| ov | output | 1 | Two-cycle terminal-count pulse |
| tc_flag | output | 1 | Sticky terminal-count flag |

## Verification
The bench builds the block with its defaults: an 8-bit counter, a period reset value of 9 and a two-cycle overflow pulse. Strobes are spaced four fast cycles apart, which leaves room to check the full overflow pulse and to fit a switch glitch that the synchronizer passes but no strobe samples. Random periods from 1 to 12 are mixed with compare values from 0 to P+1. This reaches the always-low and always-high lines, compare equal to P, and the rising and falling polarities, with swap enable toggled on and off.

// File: rtl/swap_pwm_pkg.sv
package swap_pwm_pkg;
    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_CMP    = 2'd1,
        SEL_BUF    = 2'd2,
        SEL_CTRL   = 2'd3
    } wr_sel_e;

    localparam int CTL_SWAP_EN = 0;
    localparam int CTL_FALLING = 1;
    localparam int CTL_CLR_TC  = 2;
endpackage

// File: rtl/swpwm_sync.sv
module swpwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stg_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= 1'b0;
                    else        stg_q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= 1'b0;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/swpwm_edge.sv
module swpwm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sync_in,
    input  logic falling,
    output logic edge_ev
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = prev_q;
        edge_ev = 1'b0;
        if (tick) begin
            prev_d  = sync_in;
            edge_ev = falling ? (prev_q & ~sync_in) : (~prev_q & sync_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R7: events exist only on strobes
    a_r7_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ev |-> tick);
    // R7: sampled value holds between strobes
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(prev_q));
endmodule

// File: rtl/swpwm_core.sv
module swpwm_core
    import swap_pwm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int RST_PERIOD = 9,
    parameter int OV_CYCLES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_ev,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             falling,
    output logic             line,
    output logic             line_n,
    output logic             ov,
    output logic             tc_flag
);
    localparam int OVW = $clog2(OV_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] buff;
        logic             swap_en;
        logic             fall;
        logic             seen;
        logic             irq;
        logic [OVW-1:0]   ovc;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tc_fire;
    logic     do_swap;

    always_comb begin
        st_d    = st_q;
        tc_fire = tick && (st_q.cnt >= st_q.per);
        do_swap = tc_fire && st_q.swap_en && (st_q.seen || edge_ev);

        if (st_q.ovc != '0) st_d.ovc = st_q.ovc - 1'b1;

        if (tick) begin
            if (tc_fire) st_d.cnt = '0;
            else         st_d.cnt = st_q.cnt + 1'b1;
        end

        if (tc_fire) begin
            st_d.seen = 1'b0;
            st_d.ovc  = OVW'(OV_CYCLES);
            if (do_swap) begin
                st_d.cmp  = st_q.buff;
                st_d.buff = st_q.cmp;
            end
        end else if (edge_ev) begin
            st_d.seen = 1'b1;
        end

        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_PERIOD: st_d.per  = wr_data;
                SEL_CMP:    st_d.cmp  = wr_data;
                SEL_BUF:    st_d.buff = wr_data;
                SEL_CTRL: begin
                    st_d.swap_en = wr_data[CTL_SWAP_EN];
                    st_d.fall    = wr_data[CTL_FALLING];
                    if (wr_data[CTL_CLR_TC]) st_d.irq = 1'b0;
                end
                default: ;
            endcase
        end

        if (tc_fire) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.per <= CNT_W'(RST_PERIOD);
        end else begin
            st_q     <= st_d;
        end
    end

    assign falling = st_q.fall;
    assign line    = (st_q.cnt < st_q.cmp);
    assign line_n  = ~line;
    assign ov      = (st_q.ovc != '0);
    assign tc_flag = st_q.irq;

    // R1: counter steps by one below the period
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt < st_q.per) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R1: wrap at terminal count
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tc_fire |=> st_q.cnt == '0);
    // R3: exchange at terminal count after an event
    a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_fire && st_q.swap_en && (st_q.seen || edge_ev) && !wr_en)
        |=> (st_q.cmp == $past(st_q.buff)) && (st_q.buff == $past(st_q.cmp)));
    // R5: no exchange while disabled
    a_r5_no_swap_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_fire && !st_q.swap_en && !wr_en) |=> $stable(st_q.cmp));
    // R8: overflow pulse begins only after a terminal count
    a_r8_ov_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov) |-> $past(tc_fire));
    // R9: flag set by terminal count
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tc_fire |=> tc_flag);
    // R10: event record cleared at terminal count
    a_r10_seen_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tc_fire |=> !st_q.seen);
endmodule

// File: rtl/swap_pwm.sv
module swap_pwm #(
    parameter int CNT_W       = 8,
    parameter int RST_PERIOD  = 9,
    parameter int OV_CYCLES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             sw_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             line,
    output logic             line_n,
    output logic             ov,
    output logic             tc_flag
);
    logic sw_sync;
    logic sw_edge;
    logic falling;

    swpwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sw_in),
        .dout  (sw_sync)
    );

    swpwm_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .sync_in (sw_sync),
        .falling (falling),
        .edge_ev (sw_edge)
    );

    swpwm_core #(
        .CNT_W      (CNT_W),
        .RST_PERIOD (RST_PERIOD),
        .OV_CYCLES  (OV_CYCLES)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .edge_ev (sw_edge),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .falling (falling),
        .line    (line),
        .line_n  (line_n),
        .ov      (ov),
        .tc_flag (tc_flag)
    );

    // R2: line outputs are complementary
    a_r2_compl: assert property (@(posedge clk) disable iff (!rst_n)
        line_n == ~line);
endmodule

// File: tb/sim_swap_pwm.sv
module sim_swap_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       sw_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       line, line_n, ov, tc_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the requirements
    int  m_cnt, m_per, m_cmp, m_buf;
    bit  m_en, m_fall, m_seen, m_irq, m_prev, m_tc;
    bit  sw_cur;

    swap_pwm u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .sw_in(sw_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .line(line), .line_n(line_n), .ov(ov), .tc_flag(tc_flag)
    );

    always #4 clk = ~clk;

    function automatic bit exp_line();
        return m_cnt < m_cmp;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_tick();
        bit ev;
        ev = m_fall ? (m_prev && !sw_cur) : (!m_prev && sw_cur);
        m_prev = sw_cur;
        m_tc = (m_cnt >= m_per);
        if (m_tc) begin
            if (m_en && (m_seen || ev)) begin
                int t;
                t = m_cmp; m_cmp = m_buf; m_buf = t;
            end
            m_seen = 0;
            m_irq  = 1;
            m_cnt  = 0;
        end else begin
            m_cnt = m_cnt + 1;
            if (ev) m_seen = 1;
        end
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[7:0];
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_per = data;
            1: m_cmp = data;
            2: m_buf = data;
            default: begin
                m_en = data[0]; m_fall = data[1];
                if (data[2]) m_irq = 0;
            end
        endcase
    endtask

    // one strobe, four fast cycles; nxt is the switch level for the next strobe
    task automatic step(input string req, input bit nxt, input bit glitch);
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
        model_tick();
        chk(req, line, exp_line());
        chk("R2", line_n, !exp_line());
        chk("R9", tc_flag, m_irq);
        chk("R8", ov, m_tc);
        sw_in = glitch ? !nxt : nxt;
        @(negedge clk);
        sw_in = nxt;
        sw_cur = nxt;
        chk("R8", ov, m_tc);
        @(negedge clk);
        chk("R8", ov, 0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sw_in = 1'b0; sw_cur = 0;
        m_cnt = 0; m_per = 9; m_cmp = 0; m_buf = 0;
        m_en = 0; m_fall = 0; m_seen = 0; m_irq = 0; m_prev = 0; m_tc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        // R11: reset state
        chk("R11", line, 0);
        chk("R11", line_n, 1);
        chk("R11", ov, 0);
        chk("R11", tc_flag, 0);

        // R1 R2: plain PWM, no swap, period 9 compare 2
        wr(1, 2); wr(2, 6);
        begin
            int highs;
            highs = 0;
            for (int i = 0; i < 10; i++) begin
                step("R2", 1'b0, 1'b0);
                if (line) highs++;
            end
            chk("R1", m_cnt, 0);
            chk("R2", highs, 2);
        end

        // R3 R12: loopback falling edge, high 2 low 8 high 6 low 4
        wr(3, 3);
        for (int i = 0; i < 60; i++) step("R3", !exp_line(), 1'b0);
        // R12: compare 1 and compare equal to period
        wr(1, 1); wr(2, 9);
        for (int i = 0; i < 60; i++) step("R12", !exp_line(), 1'b0);

        // R4 R10: swap enabled, switch held steady -> no swap
        wr(1, 3); wr(2, 7); wr(3, 1);
        for (int i = 0; i < 30; i++) step("R4", sw_cur, 1'b0);

        // R5: disabled, switch toggles each strobe
        wr(3, 0);
        for (int i = 0; i < 30; i++) step("R5", !sw_cur, 1'b0);

        // R6: rising edge selection with toggling switch
        wr(3, 1);
        for (int i = 0; i < 30; i++) step("R6", (i % 7) == 3, 1'b0);

        // R7: glitches between strobes raise no event
        wr(3, 1);
        for (int i = 0; i < 30; i++) step("R7", 1'b0, 1'b1);

        // R9: flag clear by control write
        wr(3, 5);
        chk("R9", tc_flag, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 19);
            if (r == 0) begin
                int p;
                p = $urandom_range(1, 12);
                wr(0, p);
            end else if (r == 1) wr(1, $urandom_range(0, m_per + 1));
            else if (r == 2) wr(2, $urandom_range(0, m_per + 1));
            else if (r == 3) wr(3, $urandom_range(0, 7));
            step("R3", $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule